// File: doc/BRIEF.md
# Coprocessor Instruction Exception Gate

This block sits at the issue stage of a simple processor core and rules on every instruction handed to it. It is given the class of the instruction (math escape, wait, or anything else), three control bits (emulate, monitor, task-switched) and the active-low error line of an external math unit. For each issued instruction it produces exactly one outcome, one clock later: either a proceed pulse or an exception request pulse. The exception request carries a 5-bit vector number. Vector 7 means the math unit is unavailable. Vector 16 means the math unit has reported an error.

Opcode decoding is done upstream. The decoder also says whether a given escape form is one that looks at the error line. Any handler that emulates the math unit, and any operand transfer to it, lives elsewhere. A vector 7 request has no error code attached, and the instruction that raised it can be restarted unchanged once the handler returns.

Top module: `fpu_issue_gate`

## Requirements
- R1: While reset is applied, and after it until the first issue, `exc_req` and `proceed` are low and `exc_vector` is 0.
- R2: An escape instruction (`issue_class` = 2'b01) issued with `ctl_em` high raises vector 7.
- R3: An escape or wait instruction (`issue_class` = 2'b10) issued with both `ctl_mp` and `ctl_ts` high raises vector 7. Either bit alone does not.
- R4: With the error line asserted (low), two kinds of issue raise vector 16 unless R2 or R3 applies. The first is an escape whose `esc_samples_err` is high. The second is a wait issued with `ctl_em` low.
- R5: The error line has no effect on an escape whose `esc_samples_err` is low, or on a wait issued with `ctl_em` high. Such an instruction proceeds.
- R6: When an instruction meets both a vector 7 condition and a vector 16 condition, vector 7 is reported.
- R7: Any other class (2'b00 or 2'b11) always proceeds, whatever the control bits and the error line are.
- R8: An issue sampled at rising edge k gives exactly one of `proceed` or `exc_req`, high for the single cycle after edge k. With no issue, both outputs stay low and `exc_vector` is 0. Back-to-back issues give back-to-back pulses.
- R9: The error line passes through two synchronizing flops. An issue sampled at the first or second rising edge after the line changes sees the old level. An issue sampled at the third edge or later sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_class | input | 2 | 01 escape, 10 wait, 00/11 other |
| esc_samples_err | input | 1 | This escape form checks the error line |
| ctl_em | input | 1 | Emulate control bit |
| ctl_mp | input | 1 | Monitor control bit |
| ctl_ts | input | 1 | Task-switched control bit |
| math_err_n | input | 1 | Active-low error from the math unit |
| exc_req | output | 1 | One-cycle exception request |
| exc_vector | output | 5 | Vector number while `exc_req` is high, else 0 |
| proceed | output | 1 | One-cycle grant to continue the instruction |

## Verification
The block holds very little state: two synchronizer flops and the output registers. A fault in the synchronizer shows up as a vector 16 decision arriving one issue early or one issue late after the error line changes. The bench targets those edge cycles directly. A fault in the output registers shows up as a missing pulse, a pulse that lasts more than one cycle, or a stray pulse in a cycle with no issue. Each of these is visible at the ports in the cycle right after the strobe. The monitor checks every cycle, so it catches each of them at once.

// File: rtl/fpu_issue_gate.sv
module fpu_issue_gate #(
  parameter int VEC_W = 5,
  parameter logic [VEC_W-1:0] VEC_NOT_AVAIL = VEC_W'(7),
  parameter logic [VEC_W-1:0] VEC_MATH_ERR  = VEC_W'(16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [1:0]       issue_class,
  input  logic             esc_samples_err,
  input  logic             ctl_em,
  input  logic             ctl_mp,
  input  logic             ctl_ts,
  input  logic             math_err_n,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vector,
  output logic             proceed
);

  localparam logic [1:0] CLS_ESC  = 2'b01;
  localparam logic [1:0] CLS_WAIT = 2'b10;

  logic [1:0] err_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) err_sync <= '0;
    else        err_sync <= {err_sync[0], ~math_err_n};
  end

  wire is_esc     = (issue_class == CLS_ESC);
  wire is_wait    = (issue_class == CLS_WAIT);
  wire na_hit     = (is_esc & ctl_em) | ((is_esc | is_wait) & ctl_mp & ctl_ts);
  wire err_window = (is_esc & esc_samples_err) | (is_wait & ~ctl_em);
  wire err_hit    = err_window & err_sync[1];
  wire trap       = na_hit | err_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req    <= 1'b0;
      exc_vector <= '0;
      proceed    <= 1'b0;
    end else begin
      exc_req    <= issue_valid & trap;
      proceed    <= issue_valid & ~trap;
      exc_vector <= !(issue_valid & trap) ? '0 :
                    na_hit ? VEC_NOT_AVAIL : VEC_MATH_ERR;
    end
  end

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_req, proceed}));

  p_pulse_needs_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req || proceed) |-> $past(issue_valid));

  p_issue_gets_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (exc_req || proceed));

  p_idle_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> (exc_vector == '0));

  p_legal_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vector == VEC_NOT_AVAIL || exc_vector == VEC_MATH_ERR));

  p_em_escape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && is_esc && ctl_em) |=> (exc_req && exc_vector == VEC_NOT_AVAIL));

  p_mp_ts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (is_esc || is_wait) && ctl_mp && ctl_ts)
      |=> (exc_req && exc_vector == VEC_NOT_AVAIL));

  p_other_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !is_esc && !is_wait) |=> proceed);

  p_err_from_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_vector == VEC_MATH_ERR) |-> !$past(math_err_n, 3));

endmodule

// File: tb/fpu_issue_gate_tb.sv
module fpu_issue_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [1:0] issue_class = 2'b00;
  logic esc_samples_err = 1'b0;
  logic ctl_em = 1'b0, ctl_mp = 1'b0, ctl_ts = 1'b0;
  logic math_err_n = 1'b1;
  logic exc_req, proceed;
  logic [4:0] exc_vector;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [6:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_issue_gate u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_class(issue_class),
    .esc_samples_err(esc_samples_err), .ctl_em(ctl_em), .ctl_mp(ctl_mp), .ctl_ts(ctl_ts),
    .math_err_n(math_err_n), .exc_req(exc_req), .exc_vector(exc_vector), .proceed(proceed)
  );

  function automatic logic [6:0] model(input logic [1:0] c, input logic s, input logic em,
                                       input logic mp, input logic ts, input logic err);
    logic esc, wt;
    esc = (c == 2'b01);
    wt  = (c == 2'b10);
    if ((esc && em) || ((esc || wt) && mp && ts)) return {1'b1, 5'd7, 1'b0};
    if (err && ((esc && s) || (wt && !em)))       return {1'b1, 5'd16, 1'b0};
    return {1'b0, 5'd0, 1'b1};
  endfunction

  task automatic issue(input logic [1:0] c, input logic s, input logic em, input logic mp,
                       input logic ts, input logic err_seen, input string tag);
    @(negedge clk);
    issue_valid = 1'b1; issue_class = c; esc_samples_err = s;
    ctl_em = em; ctl_mp = mp; ctl_ts = ts;
    exp_q.push_back(model(c, s, em, mp, ts, err_seen));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      issue_valid = 1'b0;
    end
  endtask

  task automatic set_err(input logic asserted);
    @(negedge clk);
    issue_valid = 1'b0;
    math_err_n = ~asserted;
    idle(3);
  endtask

  always @(posedge clk) begin
    logic fired;
    logic [6:0] got, exp;
    string tag;
    fired = issue_valid && rst_n;
    #1;
    if (rst_n) begin
      got = {exc_req, exc_vector, proceed};
      checks++;
      if (fired) begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
      end else begin
        exp = 7'b0;
        tag = "R8 idle";
      end
      if (got !== exp) begin
        fails++;
        $display("FAIL %s: req/vec/proceed got %b/%0d/%b expected %b/%0d/%b",
                 tag, got[6], got[5:1], got[0], exp[6], exp[5:1], exp[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    math_err_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if ({exc_req, exc_vector, proceed} !== 7'b0) begin
      fails++;
      $display("FAIL R1: outputs in reset got %b expected 0", {exc_req, exc_vector, proceed});
    end
    rst_n = 1'b1;
    math_err_n = 1'b1;
    idle(4);

    issue(2'b00, 1, 1, 1, 1, 0, "R7 other class");
    issue(2'b11, 1, 1, 1, 1, 0, "R7 class 11");
    issue(2'b01, 0, 1, 0, 0, 0, "R2 esc em");
    issue(2'b01, 1, 0, 1, 1, 0, "R3 esc mp ts");
    issue(2'b10, 0, 0, 1, 1, 0, "R3 wait mp ts");
    issue(2'b10, 0, 0, 1, 0, 0, "R3 wait mp only");
    issue(2'b01, 0, 0, 0, 1, 0, "R3 esc ts only");
    issue(2'b01, 1, 0, 0, 0, 0, "R4 esc no error");
    idle(2);

    set_err(1'b1);
    issue(2'b01, 1, 0, 0, 0, 1, "R4 esc samples error");
    issue(2'b10, 0, 0, 0, 0, 1, "R4 wait em clear");
    issue(2'b01, 0, 0, 0, 0, 1, "R5 esc not sampling");
    issue(2'b10, 0, 1, 0, 0, 1, "R5 wait em set");
    issue(2'b01, 1, 1, 0, 0, 1, "R6 esc em over error");
    issue(2'b10, 0, 0, 1, 1, 1, "R6 wait mp ts over error");
    issue(2'b00, 1, 0, 0, 0, 1, "R7 other with error");
    idle(1);
    issue(2'b01, 1, 0, 0, 0, 1, "R8 isolated pulse");
    idle(3);

    set_err(1'b0);
    @(negedge clk);
    math_err_n = 1'b0;
    issue_valid = 1'b1; issue_class = 2'b01; esc_samples_err = 1'b1;
    ctl_em = 0; ctl_mp = 0; ctl_ts = 0;
    exp_q.push_back(model(2'b01, 1, 0, 0, 0, 0)); tag_q.push_back("R9 edge 1");
    issue(2'b01, 1, 0, 0, 0, 0, "R9 edge 2");
    issue(2'b01, 1, 0, 0, 0, 1, "R9 edge 3");
    @(negedge clk);
    math_err_n = 1'b1;
    exp_q.push_back(model(2'b10, 0, 0, 0, 0, 1)); tag_q.push_back("R9 release edge 1");
    issue_class = 2'b10; esc_samples_err = 1'b0;
    issue(2'b10, 0, 0, 0, 0, 1, "R9 release edge 2");
    issue(2'b10, 0, 0, 0, 0, 0, "R9 release edge 3");
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule